// File: doc/BRIEF.md
# Stack Pointer and Frame Sequencer

This block holds the stack pointer of a small 8-bit processor whose stack lives in a fixed 64-byte window of data memory. The pointer itself is 6 bits wide. A constant page pattern is placed above it to form a 16-bit memory address, so every stack access lands between `0x00C0` and `0x00FF`. The pointer always names the next free byte. A push writes at the pointer and then moves it down. A pull first moves the pointer up and reads there. When a program nests deeper than 64 bytes, the pointer wraps around and silently overwrites older entries.

Besides single-byte pushes and pulls, the block runs fixed multi-byte frame sequences:
- a 2-byte subroutine frame that saves a 16-bit return address, and its matching return;
- a 5-byte interrupt frame that saves the program counter, index register, accumulator and condition codes, and its matching return.

A frame sequence moves one byte per clock and holds `busy` high while it runs. When it finishes, `done` pulses for one cycle. Bytes pulled by a return sequence are gathered into result registers for the core to load.

The memory array sits outside this block. It is expected to perform a write on the clock edge and to return read data in the same cycle as the address.

Top module: `stk_unit`

## Requirements
- R1: After reset, and on the clock edge after `sp_reset` is sampled high while `busy` is low, `stack_ptr` is 63 (all ones), which addresses `0x00FF`.
- R2: A push drives `mem_we`=1 with `mem_addr` equal to the current pointer's address and `mem_wdata` equal to `push_data`; the pointer is one lower after the edge.
- R3: A pull drives `mem_re`=1 with `mem_addr` equal to the address of pointer+1; the pointer is one higher after the edge.
- R4: Every stack address has bits 15..6 equal to `0000000011` and bits 5..0 equal to the pointer in use, so it lies in `0x00C0`..`0x00FF`.
- R5: Wrapping is silent in both directions. A push at `0x00C0` leaves the pointer at 63. A pull with the pointer at 63 reads `0x00C0` and leaves the pointer at 0. Beyond 64 pushes, the earliest entries are overwritten.
- R6: A subroutine frame (`call_go`) writes exactly 2 bytes on descending addresses, the low PC byte first and then the high byte. A return (`ret_go`) reads the high byte first and then the low byte, and presents them on `res_pc`.
- R7: An interrupt frame (`int_go`) writes exactly 5 bytes on descending addresses, in the order PC low, PC high, X, A, CCR. A return from interrupt (`reti_go`) reads CCR, A, X, PC high and PC low, and presents them on `res_ccr`, `res_a`, `res_x` and `res_pc`.
- R8: `busy` rises on the cycle after a frame start. Each busy cycle carries exactly one transfer. `done` is high for exactly one cycle, the cycle after the last transfer, and `busy` is low in that cycle.
- R9: While `busy` is high, `sp_reset`, push, pull and frame-start requests are ignored: the frame's transfers and the final pointer are unchanged.
- R10: When idle, simultaneous requests are served in this priority order: `sp_reset`, then frame starts (`call_go` > `ret_go` > `int_go` > `reti_go`), then push, then pull. Only the winner takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sp_reset | input | 1 | Reset-stack-pointer command |
| push_req | input | 1 | Single-byte push strobe |
| push_data | input | 8 | Byte to push |
| pull_req | input | 1 | Single-byte pull strobe |
| call_go | input | 1 | Start subroutine frame |
| call_pc | input | 16 | Return address to save |
| ret_go | input | 1 | Start subroutine return |
| int_go | input | 1 | Start interrupt frame |
| int_pc | input | 16 | Program counter to save |
| int_x | input | 8 | Index register to save |
| int_a | input | 8 | Accumulator to save |
| int_ccr | input | 8 | Condition codes to save |
| reti_go | input | 1 | Start interrupt return |
| mem_rdata | input | 8 | Read data from memory (same cycle) |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| stack_ptr | output | 6 | Current pointer value |
| busy | output | 1 | Frame sequence in progress |
| done | output | 1 | One-cycle frame completion pulse |
| res_pc | output | 16 | Program counter from the last return |
| res_x | output | 8 | Index register from the last interrupt return |
| res_a | output | 8 | Accumulator from the last interrupt return |
| res_ccr | output | 8 | Condition codes from the last interrupt return |

## Verification
Several requests can be presented in the same cycle. The bench drives them together on purpose: a pointer reset together with a push, a push together with a pull, and a frame start together with a push. In each case it checks the write and read strobes in that cycle and the pointer after the edge, so that only the higher-priority request is seen to take effect. A running frame sequence can also coincide with new requests. The bench raises a pointer reset, a push and a pull in the middle of a frame, then confirms that the frame's addresses, data and final pointer match an undisturbed run.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;
    localparam int PTR_W  = 6;
    localparam int PC_W   = 2 * DATA_W;
    localparam int PAGE_W = ADDR_W - PTR_W;
    localparam int BEAT_W = 3;

    localparam logic [PAGE_W-1:0] PAGE_DEFAULT = PAGE_W'(3);

    localparam logic [BEAT_W-1:0] CALL_LEN = BEAT_W'(2);
    localparam logic [BEAT_W-1:0] INT_LEN  = BEAT_W'(5);

    typedef enum logic [1:0] {
        XFER_NONE,
        XFER_PUSH,
        XFER_PULL
    } xfer_e;

    typedef enum logic [1:0] {
        FR_CALL,
        FR_RET,
        FR_INT,
        FR_RETI
    } frame_e;

    // Push order of the interrupt frame; the subroutine frame uses the first two.
    typedef enum logic [BEAT_W-1:0] {
        SLOT_PCL = 3'd0,
        SLOT_PCH = 3'd1,
        SLOT_X   = 3'd2,
        SLOT_A   = 3'd3,
        SLOT_CCR = 3'd4
    } slot_e;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] ccr;
    } ctx_t;

    function automatic logic [BEAT_W-1:0] frame_len(frame_e k);
        return (k == FR_CALL || k == FR_RET) ? CALL_LEN : INT_LEN;
    endfunction

    function automatic logic frame_pushes(frame_e k);
        return (k == FR_CALL || k == FR_INT);
    endfunction

    function automatic slot_e frame_slot(frame_e k, logic [BEAT_W-1:0] beat);
        slot_e s;
        case (k)
            FR_CALL, FR_INT: s = slot_e'(beat);
            FR_RET:          s = (beat == '0) ? SLOT_PCH : SLOT_PCL;
            default:         s = slot_e'(INT_LEN - BEAT_W'(1) - beat);
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] slot_read(ctx_t c, slot_e s);
        logic [DATA_W-1:0] d;
        case (s)
            SLOT_PCL: d = c.pc[DATA_W-1:0];
            SLOT_PCH: d = c.pc[PC_W-1:DATA_W];
            SLOT_X:   d = c.x;
            SLOT_A:   d = c.a;
            default:  d = c.ccr;
        endcase
        return d;
    endfunction

    function automatic ctx_t slot_write(ctx_t c, slot_e s, logic [DATA_W-1:0] d);
        ctx_t r;
        r = c;
        case (s)
            SLOT_PCL: r.pc[DATA_W-1:0]    = d;
            SLOT_PCH: r.pc[PC_W-1:DATA_W] = d;
            SLOT_X:   r.x                 = d;
            SLOT_A:   r.a                 = d;
            default:  r.ccr               = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr
    import stk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_top,
    input  logic             dec,
    input  logic             inc,
    output logic [PTR_W-1:0] ptr,
    output logic [PTR_W-1:0] ptr_up
);

    always_ff @(posedge clk) begin
        if (rst || load_top) begin
            ptr <= '1;
        end else if (dec) begin
            ptr <= ptr - PTR_W'(1);
        end else if (inc) begin
            ptr <= ptr + PTR_W'(1);
        end
    end

    // Natural modulo-64 wrap in both directions.
    assign ptr_up = ptr + PTR_W'(1);

endmodule

// File: rtl/stk_addr.sv
module stk_addr
    import stk_pkg::*;
#(
    parameter logic [PAGE_W-1:0] PAGE = PAGE_DEFAULT
) (
    input  xfer_e             xfer,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [PTR_W-1:0]  ptr_up,
    output logic [ADDR_W-1:0] addr,
    output logic              we,
    output logic              re
);

    logic [PTR_W-1:0] low;

    always_comb begin
        low  = (xfer == XFER_PULL) ? ptr_up : ptr;
        addr = {PAGE, low};
        we   = (xfer == XFER_PUSH);
        re   = (xfer == XFER_PULL);
    end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              allow,
    input  logic              call_go,
    input  logic [PC_W-1:0]   call_pc,
    input  logic              ret_go,
    input  logic              int_go,
    input  ctx_t              int_ctx,
    input  logic              reti_go,
    input  logic [DATA_W-1:0] rd_data,
    output xfer_e             xfer,
    output logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic              start,
    output ctx_t              ctx
);

    logic              active;
    frame_e            kind;
    logic [BEAT_W-1:0] beat;
    frame_e            start_kind;
    slot_e             slot;
    logic              last;

    always_comb begin
        start = allow && !active && (call_go || ret_go || int_go || reti_go);
        if (call_go)      start_kind = FR_CALL;
        else if (ret_go)  start_kind = FR_RET;
        else if (int_go)  start_kind = FR_INT;
        else              start_kind = FR_RETI;
        slot = frame_slot(kind, beat);
        last = (beat == frame_len(kind) - BEAT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            kind   <= FR_CALL;
            beat   <= '0;
            done   <= 1'b0;
            ctx    <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                kind   <= start_kind;
                beat   <= '0;
                if (start_kind == FR_CALL) begin
                    ctx.pc <= call_pc;
                end else if (start_kind == FR_INT) begin
                    ctx <= int_ctx;
                end
            end else if (active) begin
                if (!frame_pushes(kind)) begin
                    ctx <= slot_write(ctx, slot, rd_data);
                end
                if (last) begin
                    active <= 1'b0;
                    beat   <= '0;
                    done   <= 1'b1;
                end else begin
                    beat <= beat + BEAT_W'(1);
                end
            end
        end
    end

    always_comb begin
        if (!active)                 xfer = XFER_NONE;
        else if (frame_pushes(kind)) xfer = XFER_PUSH;
        else                         xfer = XFER_PULL;
        wdata = slot_read(ctx, slot);
        busy  = active;
    end

endmodule

// File: rtl/stk_unit.sv
module stk_unit
    import stk_pkg::*;
#(
    parameter logic [PAGE_W-1:0] STACK_PAGE = PAGE_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sp_reset,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pull_req,
    input  logic              call_go,
    input  logic [PC_W-1:0]   call_pc,
    input  logic              ret_go,
    input  logic              int_go,
    input  logic [PC_W-1:0]   int_pc,
    input  logic [DATA_W-1:0] int_x,
    input  logic [DATA_W-1:0] int_a,
    input  logic [DATA_W-1:0] int_ccr,
    input  logic              reti_go,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [PTR_W-1:0]  stack_ptr,
    output logic              busy,
    output logic              done,
    output logic [PC_W-1:0]   res_pc,
    output logic [DATA_W-1:0] res_x,
    output logic [DATA_W-1:0] res_a,
    output logic [DATA_W-1:0] res_ccr
);

    ctx_t              int_ctx;
    ctx_t              ctx;
    xfer_e             seq_xfer;
    xfer_e             xfer;
    logic [DATA_W-1:0] seq_wdata;
    logic              seq_busy;
    logic              seq_start;
    logic              any_go;
    logic [PTR_W-1:0]  ptr;
    logic [PTR_W-1:0]  ptr_up;

    assign int_ctx = '{pc: int_pc, x: int_x, a: int_a, ccr: int_ccr};
    assign any_go  = call_go || ret_go || int_go || reti_go;

    stk_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .allow   (!sp_reset),
        .call_go (call_go),
        .call_pc (call_pc),
        .ret_go  (ret_go),
        .int_go  (int_go),
        .int_ctx (int_ctx),
        .reti_go (reti_go),
        .rd_data (mem_rdata),
        .xfer    (seq_xfer),
        .wdata   (seq_wdata),
        .busy    (seq_busy),
        .done    (done),
        .start   (seq_start),
        .ctx     (ctx)
    );

    // Arbitration: running frame, then pointer reset, then frame start,
    // then push, then pull.
    always_comb begin
        if (seq_busy)                           xfer = seq_xfer;
        else if (sp_reset || any_go)            xfer = XFER_NONE;
        else if (push_req)                      xfer = XFER_PUSH;
        else if (pull_req)                      xfer = XFER_PULL;
        else                                    xfer = XFER_NONE;
        mem_wdata = seq_busy ? seq_wdata : push_data;
    end

    stk_ptr u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load_top (sp_reset && !seq_busy),
        .dec      (xfer == XFER_PUSH),
        .inc      (xfer == XFER_PULL),
        .ptr      (ptr),
        .ptr_up   (ptr_up)
    );

    stk_addr #(.PAGE(STACK_PAGE)) u_addr (
        .xfer   (xfer),
        .ptr    (ptr),
        .ptr_up (ptr_up),
        .addr   (mem_addr),
        .we     (mem_we),
        .re     (mem_re)
    );

    assign stack_ptr = ptr;
    assign busy      = seq_busy;
    assign res_pc    = ctx.pc;
    assign res_x     = ctx.x;
    assign res_a     = ctx.a;
    assign res_ccr   = ctx.ccr;

endmodule

// File: rtl/stk_unit_chk.sv
module stk_unit_chk
    import stk_pkg::*;
#(
    parameter logic [PAGE_W-1:0] PAGE = PAGE_DEFAULT
) (
    input logic              clk,
    input logic              rst,
    input logic              sp_reset,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_re,
    input logic [PTR_W-1:0]  stack_ptr,
    input logic              busy,
    input logic              done
);

    assert_sp_top_R1: assert property (@(posedge clk) disable iff (rst)
        (sp_reset && !busy) |=> (stack_ptr == '1));

    assert_push_dec_R2: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (stack_ptr == $past(stack_ptr) - PTR_W'(1)));

    assert_pull_inc_R3: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> (stack_ptr == $past(stack_ptr) + PTR_W'(1)));

    assert_addr_page_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> (mem_addr[ADDR_W-1:PTR_W] == PAGE));

    assert_pull_addr_R3: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> (mem_addr[PTR_W-1:0] == stack_ptr + PTR_W'(1)));

    assert_one_xfer_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, mem_re}));

    assert_busy_moves_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (mem_we || mem_re));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind stk_unit stk_unit_chk #(.PAGE(STACK_PAGE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sp_reset  (sp_reset),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .stack_ptr (stack_ptr),
    .busy      (busy),
    .done      (done)
);

// File: tb/stk_unit_test.sv
`timescale 1ns/100ps
module stk_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        sp_reset, push_req, pull_req;
    logic [7:0]  push_data;
    logic        call_go, ret_go, int_go, reti_go;
    logic [15:0] call_pc, int_pc;
    logic [7:0]  int_x, int_a, int_ccr;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, mem_re;
    logic [5:0]  stack_ptr;
    logic        busy, done;
    logic [15:0] res_pc;
    logic [7:0]  res_x, res_a, res_ccr;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [5:0] exp_sp;
    logic [7:0] mem [0:255];

    always #2.5 clk = ~clk;

    stk_unit uut (.*);

    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    assign mem_rdata = mem[mem_addr[7:0]];

    function automatic logic [15:0] sa(logic [5:0] p);
        return {10'b0000000011, p};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sp_reset = 0; push_req = 0; pull_req = 0; push_data = 0;
        call_go = 0; ret_go = 0; int_go = 0; reti_go = 0;
        call_pc = 0; int_pc = 0; int_x = 0; int_a = 0; int_ccr = 0;
    endtask

    task automatic do_push(logic [7:0] d);
        @(negedge clk); push_req = 1; push_data = d; #1;
        chk("R2", "push we", mem_we, 1);
        chk("R4", "push addr", mem_addr, sa(exp_sp));
        chk("R2", "push data", mem_wdata, d);
        @(negedge clk); push_req = 0; exp_sp = exp_sp - 1;
        chk("R2", "sp after push", stack_ptr, exp_sp);
    endtask

    task automatic do_pull(logic [7:0] d);
        @(negedge clk); pull_req = 1; #1;
        chk("R3", "pull re", mem_re, 1);
        chk("R3", "pull addr", mem_addr, sa(exp_sp + 6'd1));
        chk("R3", "pull data", mem_rdata, d);
        @(negedge clk); pull_req = 0; exp_sp = exp_sp + 1;
        chk("R3", "sp after pull", stack_ptr, exp_sp);
    endtask

    task automatic do_rsp();
        @(negedge clk); sp_reset = 1;
        @(negedge clk); sp_reset = 0; exp_sp = 6'h3F;
        chk("R1", "sp after sp_reset", stack_ptr, 6'h3F);
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        exp_sp = 6'h3F;
        chk("R1", "sp after reset", stack_ptr, 6'h3F);
        chk("R8", "busy after reset", busy, 0);
        chk("R8", "done after reset", done, 0);
        chk("R2", "we idle", mem_we, 0);
    endtask

    task automatic t_push_pull();
        do_push(8'hA1); do_push(8'hB2); do_push(8'hC3);
        do_pull(8'hC3); do_pull(8'hB2); do_pull(8'hA1);
        do_push(8'h5A); do_push(8'h6B);
        do_rsp();
    endtask

    task automatic t_wrap();
        do_rsp();
        for (int i = 0; i < 64; i++) do_push(8'(i));
        chk("R5", "sp after 64 pushes", stack_ptr, 6'h3F);
        do_push(8'hEE);
        do_pull(8'hEE);
        do_rsp();
        do_pull(8'(63));
        chk("R5", "sp wrapped to 0", stack_ptr, 6'h00);
    endtask

    task automatic t_call_ret(bit disturb);
        do_rsp();
        @(negedge clk); call_go = 1; call_pc = 16'h1234;
        @(negedge clk); call_go = 0;
        if (disturb) begin sp_reset = 1; push_req = 1; pull_req = 1; push_data = 8'h99; end
        #1;
        chk("R8", "busy after call start", busy, 1);
        chk("R6", "call beat0 addr", mem_addr, 16'h00FF);
        chk("R6", "call beat0 data", mem_wdata, 8'h34);
        chk("R6", "call beat0 we", mem_we, 1);
        @(negedge clk); #1;
        chk("R6", "call beat1 addr", mem_addr, 16'h00FE);
        chk("R6", "call beat1 data", mem_wdata, 8'h12);
        @(negedge clk);
        sp_reset = 0; push_req = 0; pull_req = 0;
        chk("R8", "done after call", done, 1);
        chk("R8", "busy at done", busy, 0);
        chk(disturb ? "R9" : "R6", "sp after call", stack_ptr, 6'h3D);
        chk("R6", "mem FF", mem[8'hFF], 8'h34);
        chk("R6", "mem FE", mem[8'hFE], 8'h12);
        @(negedge clk);
        chk("R8", "done one cycle", done, 0);
        mem[8'hFE] = 8'h9A; mem[8'hFF] = 8'hBC;
        ret_go = 1;
        @(negedge clk); ret_go = 0; #1;
        chk("R6", "ret beat0 addr", mem_addr, 16'h00FE);
        chk("R6", "ret beat0 re", mem_re, 1);
        @(negedge clk); #1;
        chk("R6", "ret beat1 addr", mem_addr, 16'h00FF);
        @(negedge clk);
        chk("R6", "res_pc", res_pc, 16'h9ABC);
        chk("R6", "sp after ret", stack_ptr, 6'h3F);
        exp_sp = 6'h3F;
    endtask

    task automatic t_int_reti();
        logic [15:0] a_exp [5];
        logic [7:0]  d_exp [5];
        a_exp = '{16'h00FF, 16'h00FE, 16'h00FD, 16'h00FC, 16'h00FB};
        d_exp = '{8'hCD, 8'hAB, 8'h11, 8'h22, 8'h05};
        do_rsp();
        @(negedge clk); int_go = 1; int_pc = 16'hABCD; int_x = 8'h11; int_a = 8'h22; int_ccr = 8'h05;
        @(negedge clk); int_go = 0;
        for (int i = 0; i < 5; i++) begin
            #1;
            chk("R7", "int addr", mem_addr, a_exp[i]);
            chk("R7", "int data", mem_wdata, d_exp[i]);
            chk("R8", "int busy", busy, 1);
            @(negedge clk);
        end
        chk("R8", "done after int", done, 1);
        chk("R7", "sp after int", stack_ptr, 6'h3A);
        mem[8'hFB] = 8'h0A; mem[8'hFC] = 8'h33; mem[8'hFD] = 8'h44;
        mem[8'hFE] = 8'h56; mem[8'hFF] = 8'h78;
        reti_go = 1;
        @(negedge clk); reti_go = 0;
        for (int i = 0; i < 5; i++) begin
            #1;
            chk("R7", "reti addr", mem_addr, a_exp[4-i]);
            chk("R7", "reti re", mem_re, 1);
            @(negedge clk);
        end
        chk("R7", "res_ccr", res_ccr, 8'h0A);
        chk("R7", "res_a", res_a, 8'h33);
        chk("R7", "res_x", res_x, 8'h44);
        chk("R7", "res_pc", res_pc, 16'h5678);
        chk("R7", "sp after reti", stack_ptr, 6'h3F);
        exp_sp = 6'h3F;
    endtask

    task automatic t_priority();
        do_rsp();
        do_push(8'h10);
        @(negedge clk); sp_reset = 1; push_req = 1; push_data = 8'h77; #1;
        chk("R10", "rsp beats push we", mem_we, 0);
        @(negedge clk); sp_reset = 0; push_req = 0; exp_sp = 6'h3F;
        chk("R10", "sp after rsp+push", stack_ptr, 6'h3F);
        @(negedge clk); push_req = 1; pull_req = 1; push_data = 8'h42; #1;
        chk("R10", "push beats pull we", mem_we, 1);
        chk("R10", "push beats pull re", mem_re, 0);
        @(negedge clk); push_req = 0; pull_req = 0; exp_sp = 6'h3E;
        chk("R10", "sp after push+pull", stack_ptr, 6'h3E);
        @(negedge clk); call_go = 1; call_pc = 16'h0102; push_req = 1; #1;
        chk("R10", "call beats push we", mem_we, 0);
        @(negedge clk); call_go = 0; push_req = 0;
        chk("R10", "busy after call+push", busy, 1);
        chk("R10", "sp after call+push", stack_ptr, 6'h3E);
        @(negedge clk); @(negedge clk);
        chk("R10", "sp after call frame", stack_ptr, 6'h3C);
        @(negedge clk); ret_go = 1; int_go = 1;
        @(negedge clk); ret_go = 0; int_go = 0;
        @(negedge clk); @(negedge clk);
        chk("R10", "ret beats int sp", stack_ptr, 6'h3E);
        chk("R10", "ret beats int pc", res_pc, 16'h0102);
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        t_reset();
        t_push_pull();
        t_wrap();
        t_call_ret(0);
        t_call_ret(1);
        t_int_reti();
        t_priority();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule